// File: doc/BRIEF.md
# Multi-Channel Hit Rate Scaler Bank

This block measures hit rates on a group of eight front-end channels, for rate and noise monitoring. Each hit line carries a level that is already synchronous to the block clock, and one hit is a low-to-high change of that level. A main counter follows whichever channel the selector names. It is built from three redundant copies that re-vote on every clock, so a single upset copy is corrected on the next clock.

A diagnostic mode adds seven plain counters, one each for channels 1 to 7, so that several channels can be watched at once. A host reads any counter through a small address-and-data read port, can clear every counter with one strobe, and starts and stops counting with a run level. All counters stop at all-ones and do not wrap.

Top module: `rate_scaler_bank`

## Requirements
- R1: While `rst` (synchronous, active high) is high at a clock edge, every counter and the edge-detection state clear, so every read address returns 0 afterwards.
- R2: A hit counts on the first clock where its line is sampled high after being sampled low. A line held high for many clocks adds exactly one.
- R3: The main counter adds one for each rising edge on the channel named by `chan_sel`. Edges on the other channels leave it unchanged.
- R4: The main counter keeps three copies. On every clock each copy loads the bitwise majority of the three, plus one when counting. The read port returns the majority value, which changes by at most one per clock unless cleared.
- R5: A clock edge where `chan_sel` differs from its value at the previous edge clears the main counter. An edge on the newly selected channel at that same clock is not counted.
- R6: Test counter k (k = 1..7) counts rising edges on channel k while `test_en` and `run` are both high. At every edge where `test_en` is low, all test counters clear, so they read 0.
- R7: `rd_data` is combinational. `rd_addr` = 0 returns the main counter and `rd_addr` = k returns test counter k.
- R8: `host_clr` high at an edge clears all counters and takes priority over a hit at that edge. It does not reset edge detection, so a line still held high afterwards is not counted again.
- R9: While `run` is low, all counters hold their values and hits are ignored.
- R10: A counter at all-ones (0xFFFFFF with the default 24-bit width) stays there on further hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 8 | Synchronous hit levels, one per channel |
| chan_sel | input | 3 | Channel followed by the main counter |
| test_en | input | 1 | Enables the seven per-channel test counters |
| run | input | 1 | Counting enabled when high |
| host_clr | input | 1 | Clears all counters |
| rd_addr | input | 3 | Read address: 0 main, 1..7 test counter |
| rd_data | output | 24 | Value of the addressed counter |

## Verification
The assertions assume that `hit_in` and `chan_sel` are already synchronous to `clk`, and that reset is held for at least one edge before any property is evaluated. The stimulus changes every input only at falling clock edges, always releases a hit line for at least one edge between pulses, and holds reset high from time zero. The saturation property is exercised by a second instance built with a 4-bit counter width. That instance reaches its ceiling within the run, which a 24-bit counter could not do.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    localparam int DEF_CNT_W = 24;
    localparam int DEF_N_CH  = 8;

    // Per-clock command to one counter: clear wins over increment.
    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_ctrl_t;

    function automatic cnt_ctrl_t make_ctrl(input logic clr, input logic inc);
        cnt_ctrl_t c;
        c.clr = clr;
        c.inc = inc & ~clr;
        return c;
    endfunction

endpackage

// File: rtl/scaler_edge.sv
module scaler_edge #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] lvl,
    output logic [N_CH-1:0] rise
);

    logic [N_CH-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // A held level yields a single rise pulse, never two in a row.
    assert_one_rise_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/scaler_counter.sv
module scaler_counter
    import scaler_pkg::*;
#(
    parameter int W         = 24,
    parameter bit REDUNDANT = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  cnt_ctrl_t ctrl,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] CEIL   = '1;
    localparam int           COPIES = REDUNDANT ? 3 : 1;

    logic [W-1:0] copy_q [COPIES];
    logic [W-1:0] cur;
    logic [W-1:0] nxt;

    generate
        if (REDUNDANT) begin : g_vote
            assign cur = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) |
                         (copy_q[1] & copy_q[2]);
        end else begin : g_single
            assign cur = copy_q[0];
        end
    endgenerate

    always_comb begin
        if (ctrl.clr)                     nxt = '0;
        else if (ctrl.inc && cur != CEIL) nxt = cur + 1'b1;
        else                              nxt = cur;
    end

    // Every copy reloads from the voted value, so a lone upset copy heals.
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst) copy_q[i] <= '0;
            else     copy_q[i] <= nxt;
        end
    end

    assign value = cur;

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl.clr)) |->
        (value == $past(value) || value == $past(value) + 1'b1));

    assert_ceiling_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl.clr) && $past(value) == CEIL) |-> value == CEIL);

endmodule

// File: rtl/rate_scaler_bank.sv
module rate_scaler_bank
    import scaler_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int N_CH  = DEF_N_CH,
    localparam int SEL_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  hit_in,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic             test_en,
    input  logic             run,
    input  logic             host_clr,
    input  logic [SEL_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data
);

    logic [N_CH-1:0]  rise;
    logic [SEL_W-1:0] sel_q;
    logic             sel_moved;
    cnt_ctrl_t        main_ctrl;
    logic [CNT_W-1:0] cnt_bank [N_CH];

    scaler_edge #(.N_CH(N_CH)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (hit_in),
        .rise (rise)
    );

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= chan_sel;
    end

    assign sel_moved = (chan_sel != sel_q);
    assign main_ctrl = make_ctrl(host_clr | sel_moved, run & rise[chan_sel]);

    scaler_counter #(.W(CNT_W), .REDUNDANT(1'b1)) u_main (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (main_ctrl),
        .value (cnt_bank[0])
    );

    for (genvar k = 1; k < N_CH; k++) begin : g_test
        cnt_ctrl_t t_ctrl;
        assign t_ctrl = make_ctrl(host_clr | ~test_en, run & test_en & rise[k]);

        scaler_counter #(.W(CNT_W), .REDUNDANT(1'b0)) u_tcnt (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (t_ctrl),
            .value (cnt_bank[k])
        );

        assert_test_idle_R6: assert property (@(posedge clk) disable iff (rst)
            !test_en |=> cnt_bank[k] == '0);
    end

    assign rd_data = cnt_bank[rd_addr];

    assert_sel_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_sel != sel_q) |=> cnt_bank[0] == '0);

    assert_host_clear_R8: assert property (@(posedge clk) disable iff (rst)
        host_clr |=> cnt_bank[0] == '0);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !host_clr && chan_sel == sel_q) |=> $stable(cnt_bank[0]));

    always_comb begin
        if (!rst) assert_read_mux_R7: assert (rd_addr != '0 || rd_data == cnt_bank[0]);
    end

endmodule

// File: tb/test_rate_scaler_bank.sv
module test_rate_scaler_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  hit = '0;
    logic [2:0]  sel = '0;
    logic        test_en = 1'b0;
    logic        run = 1'b0;
    logic        hclr = 1'b0;
    logic [2:0]  raddr = '0;
    logic [23:0] rdata;
    logic [3:0]  rdata_s;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rate_scaler_bank i_rate_scaler_bank (
        .clk(clk), .rst(rst), .hit_in(hit), .chan_sel(sel), .test_en(test_en),
        .run(run), .host_clr(hclr), .rd_addr(raddr), .rd_data(rdata)
    );

    rate_scaler_bank #(.CNT_W(4)) i_rate_scaler_bank_sat (
        .clk(clk), .rst(rst), .hit_in(hit), .chan_sel(sel), .test_en(test_en),
        .run(run), .host_clr(hclr), .rd_addr(raddr), .rd_data(rdata_s)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [23:0] exp, input string req);
        @(negedge clk);
        raddr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse(input logic [7:0] mask, input int hold);
        @(negedge clk);
        hit = mask;
        repeat (hold) @(negedge clk);
        hit = '0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 8; a++) rd(a[2:0], 24'd0, "R1 reset state");
    endtask

    task automatic t_main_count;
        @(negedge clk);
        sel = 3'd2;
        run = 1'b1;
        for (int i = 0; i < 5; i++) pulse(8'h04, 1);
        rd(3'd0, 24'd5, "R3 R4 main counts selected channel");
        for (int i = 0; i < 4; i++) pulse(8'h08, 1);
        pulse(8'hFB, 1);
        rd(3'd0, 24'd5, "R3 other channels ignored");
    endtask

    task automatic t_held_hit;
        pulse(8'h04, 6);
        rd(3'd0, 24'd6, "R2 held hit counts once");
    endtask

    task automatic t_run_low;
        @(negedge clk);
        run = 1'b0;
        pulse(8'h04, 1);
        pulse(8'h04, 1);
        rd(3'd0, 24'd6, "R9 run low freezes");
        @(negedge clk);
        run = 1'b1;
    endtask

    task automatic t_sel_change;
        @(negedge clk);
        sel = 3'd5;
        hit = 8'h20;
        @(negedge clk);
        hit = '0;
        rd(3'd0, 24'd0, "R5 selector change clears");
        for (int i = 0; i < 3; i++) pulse(8'h20, 1);
        rd(3'd0, 24'd3, "R5 counts new channel");
    endtask

    task automatic t_test_mode;
        @(negedge clk);
        test_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            logic [7:0] m;
            m = '0;
            for (int k = 1; k < 8; k++) if (k > i) m[k] = 1'b1;
            pulse(m, 1);
        end
        for (int k = 1; k < 8; k++) rd(k[2:0], k, "R6 R7 test counter k");
        rd(3'd0, 24'd8, "R7 address 0 main");
        @(negedge clk);
        test_en = 1'b0;
        rd(3'd3, 24'd0, "R6 test off reads zero");
        rd(3'd7, 24'd0, "R6 test off reads zero");
    endtask

    task automatic t_host_clear;
        @(negedge clk);
        test_en = 1'b1;
        pulse(8'h02, 1);
        rd(3'd1, 24'd1, "R6 test counter re-enabled");
        @(negedge clk);
        hclr = 1'b1;
        hit = 8'h20;
        @(negedge clk);
        hclr = 1'b0;
        repeat (2) @(negedge clk);
        hit = '0;
        rd(3'd0, 24'd0, "R8 host clear main");
        rd(3'd5, 24'd0, "R8 host clear test 5");
        rd(3'd1, 24'd0, "R8 host clear test 1");
    endtask

    task automatic t_saturate;
        @(negedge clk);
        sel = 3'd0;
        test_en = 1'b0;
        for (int i = 0; i < 20; i++) pulse(8'h01, 1);
        rd(3'd0, 24'd20, "R3 main channel 0");
        check("R10 saturates at ceiling", {20'd0, rdata_s}, 24'd15);
    endtask

    initial begin
        t_reset();
        t_main_count();
        t_held_hit();
        t_run_low();
        t_sel_change();
        t_test_mode();
        t_host_clear();
        t_saturate();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule